// File: doc/BRIEF.md
# Floating-Point Compare Flag Generator

This unit compares two IEEE-754 operands and turns the outcome into a four-bit condition code. The code holds a negative flag, a zero flag, a carry flag and an overflow flag. A per-operation format select picks half, single or double precision. A per-operation mode bit picks the NaN policy. In quiet mode only a signalling NaN is an invalid operation. In signalling mode any NaN is an invalid operation. An optional flush-to-zero control turns denormal inputs into zeros of the same sign before the comparison, and reports that it did so.

The compare happens in one clock cycle. A request presented with `in_valid` appears on the registered outputs on the next cycle, marked by `out_valid`. The outputs hold their last value while no request arrives. An integer pipeline or a status-register writer can use the code directly, because each relation maps onto the flags that the following conditional branch tests.

Top module: `fp_cmp_flags`

## Requirements
- R1: When the operands compare equal, `nzcv` is 4'b0110 (Z and C set, N and V clear).
- R2: When operand A is less than operand B, `nzcv` is 4'b1000 (only N set). Negative values order below positive values, and for two negative values the larger magnitude is the lesser value.
- R3: When operand A is greater than operand B, `nzcv` is 4'b0010 (only C set). Infinities order beyond every finite value of the same sign.
- R4: When either operand is a NaN (exponent all ones, fraction nonzero), the result is unordered and `nzcv` is 4'b0011 (C and V set, N and Z clear).
- R5: `fmt` = 0 selects half precision from bits [15:0], 1 selects single precision from bits [31:0], and 2 or 3 selects double precision from bits [63:0]. Operand bits above the selected width have no effect on any output.
- R6: With `sig_mode` = 0, `invalid` is 1 only if an operand is a signalling NaN, meaning a NaN whose most significant fraction bit is 0. A quiet NaN gives `invalid` = 0.
- R7: With `sig_mode` = 1, `invalid` is 1 if either operand is any NaN. For ordered operands it is 0.
- R8: +0 and -0 compare equal in every format.
- R9: With `ftz` = 1, a denormal operand (exponent zero, fraction nonzero) is compared as a zero of its own sign, and `denorm_in` is 1. With `ftz` = 0, denormals are compared by their value and `denorm_in` is 0.
- R10: The result of a request taken with `in_valid` appears on the outputs one clock later with `out_valid` = 1. In a cycle with no request, `out_valid` is 0 and the other outputs keep their values. Synchronous reset clears every output to 0.
- R11: The flag vector is ordered N, Z, C, V from bit 3 down to bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A compare request is present |
| fmt | input | 2 | Precision select: 0 half, 1 single, 2 or 3 double |
| sig_mode | input | 1 | 1 selects signalling NaN policy, 0 selects quiet |
| ftz | input | 1 | Flush denormal inputs to signed zero |
| op_a | input | 64 | First operand, right-aligned |
| op_b | input | 64 | Second operand, right-aligned |
| out_valid | output | 1 | Result registers were loaded last cycle |
| nzcv | output | 4 | Condition flags N, Z, C, V (bit 3 to bit 0) |
| invalid | output | 1 | Invalid-operation indication |
| denorm_in | output | 1 | A denormal input was flushed |

## Verification
A wrong classification of an operand shows on the port in the cycle after the request. It shows either as a flag pattern from the wrong relation or as a legal-looking pattern paired with a wrong `invalid`. The directed cases are chosen so that each such error changes the visible code. Sign-magnitude ordering errors appear only for negative operands, and zero-sign errors appear only when +0 meets -0, so those pairs are driven explicitly. Field-boundary mistakes between the formats show up when garbage is placed above the selected width.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    localparam int OPW    = 64;
    localparam int KEYW   = OPW - 1;
    localparam int NFMT   = 3;

    localparam int H_EXPW = 5;
    localparam int H_MANW = 10;
    localparam int S_EXPW = 8;
    localparam int S_MANW = 23;
    localparam int D_EXPW = 11;
    localparam int D_MANW = 52;

    typedef enum logic [1:0] {
        FMT_HALF   = 2'd0,
        FMT_SINGLE = 2'd1,
        FMT_DOUBLE = 2'd2,
        FMT_DBLALT = 2'd3
    } fp_fmt_e;

    typedef enum logic [1:0] {
        REL_EQ = 2'd0,
        REL_LT = 2'd1,
        REL_GT = 2'd2,
        REL_UN = 2'd3
    } fp_rel_e;

    typedef struct packed {
        logic            sign;
        logic            zero;
        logic            nan;
        logic            snan;
        logic            flushed;
        logic [KEYW-1:0] key;
    } fp_class_t;

    function automatic int exp_width(int f);
        return (f == 0) ? H_EXPW : (f == 1) ? S_EXPW : D_EXPW;
    endfunction

    function automatic int man_width(int f);
        return (f == 0) ? H_MANW : (f == 1) ? S_MANW : D_MANW;
    endfunction

    function automatic int fmt_index(fp_fmt_e f);
        case (f)
            FMT_HALF:   return 0;
            FMT_SINGLE: return 1;
            default:    return 2;
        endcase
    endfunction

    function automatic logic [3:0] rel_to_flags(fp_rel_e r);
        case (r)
            REL_EQ:  return 4'b0110;
            REL_LT:  return 4'b1000;
            REL_GT:  return 4'b0010;
            default: return 4'b0011;
        endcase
    endfunction

endpackage

// File: rtl/fcmp_unpack.sv
module fcmp_unpack
    import fcmp_pkg::*;
(
    input  fp_fmt_e              fmt,
    input  logic                 ftz,
    input  logic [OPW-1:0]       op,
    output fp_class_t            cls
);

    fp_class_t per_fmt [NFMT];

    for (genvar g = 0; g < NFMT; g++) begin : g_fmt
        localparam int EW = exp_width(g);
        localparam int MW = man_width(g);

        logic          sgn;
        logic [EW-1:0] ex;
        logic [MW-1:0] mn;
        logic          exp_max;
        logic          exp_nil;
        logic          man_nz;
        logic          is_sub;

        assign sgn     = op[EW+MW];
        assign ex      = op[EW+MW-1:MW];
        assign mn      = op[MW-1:0];
        assign exp_max = &ex;
        assign exp_nil = ~|ex;
        assign man_nz  = |mn;
        assign is_sub  = exp_nil & man_nz;

        always_comb begin
            per_fmt[g].sign    = sgn;
            per_fmt[g].nan     = exp_max & man_nz;
            per_fmt[g].snan    = exp_max & man_nz & ~mn[MW-1];
            per_fmt[g].flushed = ftz & is_sub;
            per_fmt[g].zero    = exp_nil & (~man_nz | ftz);
            per_fmt[g].key     = '0;
            if (!(ftz & is_sub)) begin
                per_fmt[g].key[EW+MW-1:0] = {ex, mn};
            end
        end
    end

    assign cls = per_fmt[fmt_index(fmt)];

endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
    import fcmp_pkg::*;
(
    input  fp_class_t a,
    input  fp_class_t b,
    output fp_rel_e   rel
);

    logic mag_lt;
    logic mag_eq;

    assign mag_lt = a.key < b.key;
    assign mag_eq = a.key == b.key;

    always_comb begin
        if (a.nan || b.nan) begin
            rel = REL_UN;
        end else if (a.zero && b.zero) begin
            rel = REL_EQ;
        end else if (a.sign != b.sign) begin
            rel = a.sign ? REL_LT : REL_GT;
        end else if (mag_eq) begin
            rel = REL_EQ;
        end else if (mag_lt ^ a.sign) begin
            rel = REL_LT;
        end else begin
            rel = REL_GT;
        end
    end

endmodule

// File: rtl/fcmp_flags.sv
module fcmp_flags
    import fcmp_pkg::*;
(
    input  fp_rel_e    rel,
    input  fp_class_t  a,
    input  fp_class_t  b,
    input  logic       sig_mode,
    output logic [3:0] flags,
    output logic       inv,
    output logic       dnm
);

    logic any_nan;
    logic any_snan;

    assign any_nan  = a.nan | b.nan;
    assign any_snan = a.snan | b.snan;
    assign flags    = rel_to_flags(rel);
    assign inv      = any_snan | (sig_mode & any_nan);
    assign dnm      = a.flushed | b.flushed;

endmodule

// File: rtl/fp_cmp_flags.sv
module fp_cmp_flags
    import fcmp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [1:0]  fmt,
    input  logic        sig_mode,
    input  logic        ftz,
    input  logic [63:0] op_a,
    input  logic [63:0] op_b,
    output logic        out_valid,
    output logic [3:0]  nzcv,
    output logic        invalid,
    output logic        denorm_in
);

    fp_fmt_e    fmt_e;
    fp_class_t  cls [2];
    fp_rel_e    rel;
    logic [3:0] flags_c;
    logic       inv_c;
    logic       dnm_c;

    assign fmt_e = fp_fmt_e'(fmt);

    for (genvar i = 0; i < 2; i++) begin : g_op
        fcmp_unpack u_unpack (
            .fmt (fmt_e),
            .ftz (ftz),
            .op  ((i == 0) ? op_a : op_b),
            .cls (cls[i])
        );
    end

    fcmp_order u_order (
        .a   (cls[0]),
        .b   (cls[1]),
        .rel (rel)
    );

    fcmp_flags u_flags (
        .rel      (rel),
        .a        (cls[0]),
        .b        (cls[1]),
        .sig_mode (sig_mode),
        .flags    (flags_c),
        .inv      (inv_c),
        .dnm      (dnm_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            nzcv      <= 4'b0000;
            invalid   <= 1'b0;
            denorm_in <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                nzcv      <= flags_c;
                invalid   <= inv_c;
                denorm_in <= dnm_c;
            end
        end
    end

endmodule

// File: rtl/fcmp_checks.sv
module fcmp_checks (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       sig_mode,
    input logic       ftz,
    input logic       out_valid,
    input logic [3:0] nzcv,
    input logic       invalid,
    input logic       denorm_in
);

    // R1 R2 R3 R4 R11: only the four legal codes ever appear
    a_r11_legal_code: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (nzcv == 4'b0110 || nzcv == 4'b1000 ||
                       nzcv == 4'b0010 || nzcv == 4'b0011));

    // R6 R7: invalid is only raised for an unordered result
    a_r6_invalid_unordered: assert property (@(posedge clk) disable iff (rst)
        (out_valid && invalid) |-> nzcv == 4'b0011);

    // R7: signalling mode always flags unordered results
    a_r7_sig_nan: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(sig_mode) && nzcv == 4'b0011) |-> invalid);

    // R9: flush indication only when flushing was requested
    a_r9_flush_enable: assert property (@(posedge clk) disable iff (rst)
        (out_valid && denorm_in) |-> $past(ftz));

    // R10: one-cycle latency
    a_r10_latency: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R10: outputs hold while idle
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(nzcv) && $stable(invalid) && $stable(denorm_in)));

endmodule

bind fp_cmp_flags fcmp_checks u_checks (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .sig_mode  (sig_mode),
    .ftz       (ftz),
    .out_valid (out_valid),
    .nzcv      (nzcv),
    .invalid   (invalid),
    .denorm_in (denorm_in)
);

// File: tb/sim_fp_cmp_flags.sv
module sim_fp_cmp_flags;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    localparam logic [3:0] EQ = 4'b0110;
    localparam logic [3:0] LT = 4'b1000;
    localparam logic [3:0] GT = 4'b0010;
    localparam logic [3:0] UN = 4'b0011;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  fmt = 2'd0;
    logic        sig_mode = 1'b0;
    logic        ftz = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic        out_valid;
    logic [3:0]  nzcv;
    logic        invalid;
    logic        denorm_in;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fp_cmp_flags u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .fmt(fmt),
        .sig_mode(sig_mode), .ftz(ftz), .op_a(op_a), .op_b(op_b),
        .out_valid(out_valid), .nzcv(nzcv), .invalid(invalid),
        .denorm_in(denorm_in)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one request, sample result the cycle after
    task automatic run(string req, logic [1:0] f, logic s, logic z,
                       logic [63:0] a, logic [63:0] b,
                       logic [3:0] e_flags, logic e_inv, logic e_dnm);
        @(negedge clk);
        in_valid = 1'b1; fmt = f; sig_mode = s; ftz = z; op_a = a; op_b = b;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " flags"}, {4'b0, nzcv}, {4'b0, e_flags});
        check({req, " invalid"}, {7'b0, invalid}, {7'b0, e_inv});
        check({req, " denorm"}, {7'b0, denorm_in}, {7'b0, e_dnm});
        check({req, " valid"}, {7'b0, out_valid}, 8'd1);
    endtask

    task automatic t_reset();
        check("R10 reset valid", {7'b0, out_valid}, 8'd0);
        check("R10 reset flags", {4'b0, nzcv}, 8'd0);
        check("R10 reset invalid", {6'b0, invalid, denorm_in}, 8'd0);
    endtask

    task automatic t_ordering();
        run("R2 half 1<2", 2'd0, 0, 0, 64'h3C00, 64'h4000, LT, 0, 0);
        run("R3 single 2>1", 2'd1, 0, 0, 64'h4000_0000, 64'h3F80_0000, GT, 0, 0);
        run("R1 double 1==1", 2'd2, 0, 0, 64'h3FF0_0000_0000_0000,
            64'h3FF0_0000_0000_0000, EQ, 0, 0);
        run("R2 single -2<1", 2'd1, 0, 0, 64'hC000_0000, 64'h3F80_0000, LT, 0, 0);
        run("R2 single -2<-1", 2'd1, 0, 0, 64'hC000_0000, 64'hBF80_0000, LT, 0, 0);
        run("R3 single -1>-2", 2'd1, 0, 0, 64'hBF80_0000, 64'hC000_0000, GT, 0, 0);
        run("R3 half inf>max", 2'd0, 0, 0, 64'h7C00, 64'h7BFF, GT, 0, 0);
        run("R2 fmt3 double -inf<-1", 2'd3, 0, 0, 64'hFFF0_0000_0000_0000,
            64'hBFF0_0000_0000_0000, LT, 0, 0);
    endtask

    task automatic t_zeros();
        run("R8 half +0==-0", 2'd0, 0, 0, 64'h0000, 64'h8000, EQ, 0, 0);
        run("R8 double -0==+0", 2'd2, 0, 0, 64'h8000_0000_0000_0000, 64'h0, EQ, 0, 0);
        run("R2 R8 half -0<1", 2'd0, 0, 0, 64'h8000, 64'h3C00, LT, 0, 0);
    endtask

    task automatic t_upper_bits();
        run("R5 half upper ignored", 2'd0, 0, 0, 64'hFFFF_FFFF_FFFF_3C00,
            64'h1234_5678_9ABC_4000, LT, 0, 0);
        run("R5 single upper ignored", 2'd1, 0, 0, 64'hFFFF_FFFF_3F80_0000,
            64'h0000_0000_3F80_0000, EQ, 0, 0);
        run("R5 half upper nan-like ignored", 2'd0, 1, 0, 64'h7FFF_FFFF_0000_4000,
            64'h0000_0000_0000_3C00, GT, 0, 0);
    endtask

    task automatic t_nans();
        run("R4 R6 quiet qnan half", 2'd0, 0, 0, 64'h7E00, 64'h3C00, UN, 0, 0);
        run("R4 R6 quiet snan single", 2'd1, 0, 0, 64'h3F80_0000, 64'h7F80_0001, UN, 1, 0);
        run("R4 R7 sig qnan double", 2'd2, 1, 0, 64'h7FF8_0000_0000_0000,
            64'h3FF0_0000_0000_0000, UN, 1, 0);
        run("R7 sig ordered", 2'd2, 1, 0, 64'h3FF0_0000_0000_0000,
            64'h4000_0000_0000_0000, LT, 0, 0);
        run("R6 quiet snan double", 2'd2, 0, 0, 64'h7FF0_0000_0000_0001,
            64'h7FF0_0000_0000_0001, UN, 1, 0);
        run("R4 R6 nan vs inf", 2'd1, 0, 0, 64'h7F80_0000, 64'hFFC0_0000, UN, 0, 0);
    endtask

    task automatic t_denormals();
        run("R9 no ftz half denorm>0", 2'd0, 0, 0, 64'h0001, 64'h0000, GT, 0, 0);
        run("R9 ftz half denorm==-0", 2'd0, 0, 1, 64'h0001, 64'h8000, EQ, 0, 1);
        run("R9 ftz single -den==+den", 2'd1, 0, 1, 64'h8000_0001, 64'h0000_0001, EQ, 0, 1);
        run("R9 no ftz single -den<+den", 2'd1, 0, 0, 64'h8000_0001, 64'h0000_0001, LT, 0, 0);
        run("R9 ftz double normal", 2'd2, 0, 1, 64'h0010_0000_0000_0000, 64'h1, GT, 0, 1);
    endtask

    task automatic t_idle_hold();
        run("R10 before idle", 2'd1, 1, 0, 64'h7FC0_0000, 64'h0, UN, 1, 0);
        @(negedge clk);
        op_a = 64'h3C00; op_b = 64'h3C00; fmt = 2'd0; sig_mode = 0;
        @(negedge clk);
        check("R10 idle valid", {7'b0, out_valid}, 8'd0);
        check("R10 idle flags held", {4'b0, nzcv}, {4'b0, UN});
        check("R10 idle invalid held", {7'b0, invalid}, 8'd1);
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ordering();
        t_zeros();
        t_upper_bits();
        t_nans();
        t_denormals();
        t_idle_hold();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule